// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Acknowledge Controller

This block serves a group of peripherals that share a single interrupt priority level. Each peripheral raises a request by pulsing its bit of `dev_raise`; the request is held as a pending flag. The block presents the OR of all pending flags to the processor as one shared request line. When the processor starts an acknowledge, a grant token enters the chain at device 0, which sits nearest the CPU. Each link passes the token on only if its own device has nothing pending. The first pending device keeps the token, and that device's programmable 8-bit vector number is returned on the vector bus. The processor therefore learns which handler to run without polling the devices one by one.

Each device has its own vector register, written through a small configuration port. When no device holds the token, the block returns a fixed spurious vector. Once the response has been presented, the winner's pending flag is cleared.

The acknowledge is handled by a three-state machine. **IDLE** waits for `iack_req`; the transition *start* (IDLE→CHAIN) fires when `iack_req` is sampled high. In **CHAIN** the grant token runs through the links and the winner and its vector are captured; the transition *capture* (CHAIN→RESP) always follows. In **RESP** the vector is presented for one cycle and the winner's flag is cleared on the closing edge; the transition *finish* (RESP→IDLE) always follows. IDLE holds itself through the *wait* transition while `iack_req` is low.

Top module: `daisy_iack_ctrl`

## Requirements
- R1: `irq_out` is high exactly when at least one device has a pending flag. A `dev_raise` bit sampled at a clock edge sets that device's flag, and `irq_out` reflects the new flag after that same edge.
- R2: After reset, no flag is pending, `irq_out`, `vec_valid`, `vec_spurious` and `ack_grant` are 0, the machine is in IDLE, and the vector of device i holds VEC_BASE + i (0x40 + i by default).
- R3: A configuration write with `cfg_we` high loads `cfg_vec` into the vector register of device `cfg_idx`. Later acknowledges won by that device return the new value.
- R4: The grant goes to the pending device with the lowest index (index 0 is nearest the CPU). `ack_grant` is a one-hot mask of the winner, with bit i standing for device i.
- R5: When `iack_req` is sampled high at edge k while IDLE, `vec_valid` is high for exactly the one cycle between edges k+1 and k+2. During that cycle `vec_out` carries the winner's vector. Outside that cycle `vec_out` is 0.
- R6: If no device is pending when the grant is issued, the response carries vector 0x18 with `vec_spurious` high and `ack_grant` at 0, and no pending flag changes.
- R7: At the edge that closes the response cycle, the winner's pending flag is cleared. The flags of all other devices are unchanged.
- R8: If the winner's `dev_raise` bit is high at the same edge that clears its flag, the new request wins and the flag stays pending.
- R9: `iack_req` is ignored while the machine is in CHAIN or RESP. Holding it high through an acknowledge yields exactly one response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_raise | input | NUM_DEV | Per-device request pulse; sets the pending flag |
| cfg_we | input | 1 | Vector register write enable |
| cfg_idx | input | IDX_W | Device index for a vector write |
| cfg_vec | input | VEC_W | Vector value to write |
| iack_req | input | 1 | Processor acknowledge request |
| irq_out | output | 1 | Shared interrupt request (OR of pending flags) |
| vec_valid | output | 1 | Vector response cycle |
| vec_out | output | VEC_W | Vector number supplied during the response |
| vec_spurious | output | 1 | Response carries the spurious vector |
| ack_grant | output | NUM_DEV | One-hot mask of the device that kept the grant |

## Verification
The collision that matters is a new request from the winning device arriving at the same edge that clears that device's flag. The bench provokes it by driving the winner's `dev_raise` bit during the response cycle. It then judges the result by two checks: `irq_out` must stay high, and the next acknowledge must return the same device again. A second overlap is a configuration write landing between two acknowledges that the same device wins. Random rounds mix raises, writes and acknowledges, and every response is compared against a bench model of the flags and the vector registers.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHAIN = 2'd1,
        ST_RESP  = 2'd2
    } ack_state_t;
endpackage

// File: rtl/dc_ack_fsm.sv
module dc_ack_fsm
    import dc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iack_req,
    output logic chain_en,
    output logic resp_en
);
    ack_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (iack_req) state_d = ST_CHAIN;   // start
            ST_CHAIN: state_d = ST_RESP;                  // capture
            ST_RESP:  state_d = ST_IDLE;                  // finish
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        chain_en = 1'b0;
        resp_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CHAIN: chain_en = 1'b1;
            ST_RESP:  resp_en  = 1'b1;
            default:  ;
        endcase
    end

    // R5
    resp_after_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESP) |-> ($past(state_q) == ST_CHAIN));

    // R9
    no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_CHAIN));
endmodule

// File: rtl/dc_chain_link.sv
module dc_chain_link (
    input  logic grant_in,
    input  logic pending,
    output logic grant_out,
    output logic take
);
    assign take      = grant_in & pending;
    assign grant_out = grant_in & ~pending;
endmodule

// File: rtl/dc_vec_regs.sv
module dc_vec_regs #(
    parameter int NUM_DEV  = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 8'h40,
    localparam int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VEC_W-1:0]   wr_vec,
    input  logic [NUM_DEV-1:0] rd_sel,
    output logic [VEC_W-1:0]   rd_vec
);
    logic [VEC_W-1:0] vec_q [NUM_DEV];

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_vreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vec_q[i] <= VEC_W'(VEC_BASE + i);
            else if (wr_en && (int'(wr_idx) == i))
                vec_q[i] <= wr_vec;
        end
    end

    always_comb begin
        rd_vec = '0;
        for (int i = 0; i < NUM_DEV; i++)
            if (rd_sel[i]) rd_vec = rd_vec | vec_q[i];
    end
endmodule

// File: rtl/daisy_iack_ctrl.sv
module daisy_iack_ctrl #(
    parameter int NUM_DEV  = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 8'h40,
    parameter int SPUR_VEC = 8'h18,
    localparam int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] dev_raise,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [VEC_W-1:0]   cfg_vec,
    input  logic               iack_req,
    output logic               irq_out,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_spurious,
    output logic [NUM_DEV-1:0] ack_grant
);
    logic               chain_en, resp_en;
    logic [NUM_DEV-1:0] pend_q, take, win_q;
    logic [NUM_DEV:0]   grant;
    logic [VEC_W-1:0]   rd_vec, vec_q;
    logic               spur_q;

    dc_ack_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .iack_req (iack_req),
        .chain_en (chain_en),
        .resp_en  (resp_en)
    );

    dc_vec_regs #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_vec (cfg_vec),
        .rd_sel (take),
        .rd_vec (rd_vec)
    );

    // grant token enters at device 0 (nearest the CPU)
    assign grant[0] = chain_en;
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_link
        dc_chain_link u_link (
            .grant_in  (grant[i]),
            .pending   (pend_q[i]),
            .grant_out (grant[i+1]),
            .take      (take[i])
        );
    end

    // pending flags: a new raise wins over the clear of the winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= '0;
        else if (resp_en) pend_q <= (pend_q & ~win_q) | dev_raise;
        else              pend_q <= pend_q | dev_raise;
    end

    // capture winner and its vector at the end of CHAIN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            vec_q  <= '0;
            spur_q <= 1'b0;
        end else if (chain_en) begin
            win_q  <= take;
            vec_q  <= (|take) ? rd_vec : VEC_W'(SPUR_VEC);
            spur_q <= ~(|take);
        end
    end

    assign irq_out      = |pend_q;
    assign vec_valid    = resp_en;
    assign vec_out      = resp_en ? vec_q : '0;
    assign vec_spurious = resp_en & spur_q;
    assign ack_grant    = resp_en ? win_q : '0;

    // R1
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ($past(dev_raise) != '0));

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_grant));

    // R6
    spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_spurious |-> (vec_out == VEC_W'(SPUR_VEC) && ack_grant == '0));

    // R7
    winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ((dev_raise & ack_grant) == '0))
            |=> ((pend_q & $past(ack_grant)) == '0));
endmodule

// File: tb/daisy_iack_ctrl_test.sv
module daisy_iack_ctrl_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_raise = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_idx = '0;
    logic [7:0]   cfg_vec = '0;
    logic         iack_req = 1'b0;
    logic         irq_out, vec_valid, vec_spurious;
    logic [7:0]   vec_out;
    logic [N-1:0] ack_grant;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] pend_m;
    logic [7:0]   vec_m [N];

    always #10 clk = ~clk;

    daisy_iack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dev_raise(dev_raise),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vec(cfg_vec),
        .iack_req(iack_req), .irq_out(irq_out), .vec_valid(vec_valid),
        .vec_out(vec_out), .vec_spurious(vec_spurious), .ack_grant(ack_grant)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int first_pend(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic raise(input logic [N-1:0] m);
        dev_raise = m;
        @(negedge clk);
        dev_raise = '0;
        pend_m |= m;
        chk(irq_out == (|pend_m), "R1 irq_out", irq_out, |pend_m);
    endtask

    task automatic cfg(input int idx, input logic [7:0] v);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_vec = v;
        @(negedge clk);
        cfg_we = 1'b0;
        vec_m[idx] = v;
    endtask

    // one acknowledge; collide is driven during the response cycle
    task automatic ack(input logic [N-1:0] collide, input bit hold);
        int w;
        logic [7:0] ev;
        logic [N-1:0] eg;
        iack_req = 1'b1;
        @(negedge clk);                       // CHAIN
        chk(vec_valid == 1'b0, "R5 no early vec_valid", vec_valid, 0);
        if (!hold) iack_req = 1'b0;
        @(negedge clk);                       // RESP
        w  = first_pend(pend_m);
        ev = (w >= 0) ? vec_m[w] : 8'h18;
        eg = (w >= 0) ? N'(1 << w) : '0;
        chk(vec_valid == 1'b1, "R5 vec_valid", vec_valid, 1);
        chk(vec_out == ev, (w >= 0) ? "R3/R5 vec_out" : "R6 spurious vector", vec_out, ev);
        chk(ack_grant == eg, "R4 ack_grant", ack_grant, eg);
        chk(vec_spurious == (w < 0), "R6 vec_spurious", vec_spurious, (w < 0));
        dev_raise = collide;
        @(negedge clk);                       // back in IDLE
        dev_raise = '0;
        iack_req = 1'b0;
        if (w >= 0) pend_m &= ~eg;
        pend_m |= collide;
        chk(irq_out == (|pend_m), "R7/R8 irq_out after clear", irq_out, |pend_m);
        chk(vec_valid == 1'b0, "R5 single cycle", vec_valid, 0);
        if (hold) begin
            @(negedge clk);
            chk(vec_valid == 1'b0, "R9 held iack ignored", vec_valid, 0);
            @(negedge clk);
            chk(vec_valid == 1'b0, "R9 held iack ignored", vec_valid, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h229);
        pend_m = '0;
        for (int i = 0; i < N; i++) vec_m[i] = 8'(8'h40 + i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(irq_out == 0, "R2 irq_out", irq_out, 0);
        chk(vec_valid == 0, "R2 vec_valid", vec_valid, 0);
        chk(vec_spurious == 0, "R2 vec_spurious", vec_spurious, 0);
        chk(ack_grant == 0, "R2 ack_grant", ack_grant, 0);
        // R6 spurious with nothing pending, nothing changes
        ack('0, 1'b0);
        // R2 default vectors, R4 order
        raise(4'b1111);
        for (int i = 0; i < N; i++) ack('0, 1'b0);
        // R4 priority by position
        raise(4'b1010);
        ack('0, 1'b0);
        raise(4'b0100);
        ack('0, 1'b0);
        ack('0, 1'b0);
        // R3 vector writes
        cfg(2, 8'hA5);
        cfg(0, 8'h3C);
        raise(4'b0101);
        ack('0, 1'b0);
        ack('0, 1'b0);
        // R8 collision: winner raises during response
        raise(4'b0010);
        ack(4'b0010, 1'b0);
        chk(irq_out == 1'b1, "R8 still pending", irq_out, 1);
        ack('0, 1'b0);
        // R9 held acknowledge
        raise(4'b1000);
        ack('0, 1'b1);
        chk(irq_out == 1'b0, "R9/R7 only one clear", irq_out, 0);
        // random rounds
        for (int r = 0; r < 300; r++) begin
            int op;
            op = int'($urandom_range(0, 3));
            if (op == 0) raise(N'($urandom_range(0, (1 << N) - 1)));
            else if (op == 1) cfg(int'($urandom_range(0, N - 1)), 8'($urandom_range(0, 255)));
            else ack((op == 3) ? N'($urandom_range(0, (1 << N) - 1)) : '0, ($urandom_range(0, 4) == 0));
        end
        // drain
        while (pend_m != '0) ack('0, 1'b0);
        chk(irq_out == 1'b0, "R1 drained", irq_out, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule